// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block sits between a transmit cell queue and a line framer and turns a stream of 53-byte ATM cells into an unbroken byte stream, one byte per clock. For each cell it can compute the header check byte from the four leading header bytes, or pass the check byte supplied upstream through untouched. When no user cell is waiting at a cell boundary, it sends a filler cell (idle or unassigned), so the line rate is kept independent of the traffic rate.

Two further options sit on the same path. A self-synchronizing x^43 + 1 scrambler can be applied to the 48 payload bytes of every cell. A test injector can flip one bit of the check byte in a repeating pattern: a run of corrupted cells followed by a run of clean cells. The upstream side is a valid/ready byte interface with a start-of-cell flag. The downstream side has no back-pressure.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: The output carries back-to-back 53-byte cells with no gaps. `out_sop` is high on byte 0 of every cell and on no other byte. Each output byte is registered, so it appears one clock after the cycle in which it is selected.
- R2: A user cell starts only at a cell boundary, and only when `in_valid` and `in_sop` are both high there. Once started, it runs to completion. `in_ready` is high at every boundary and on every byte of a user cell. A boundary byte without `in_sop` is consumed and dropped. User header bytes 0 to 3 appear on the output unchanged and in order.
- R3: With `cfg_hec_insert` = 1, byte 4 of a user cell is the CRC-8 of header bytes 0 to 3. The CRC uses generator x^8 + x^2 + x + 1, a zero initial value and MSB-first bit order. It is XORed with 0x55 unless `cfg_user_coset_off` = 1.
- R4: With `cfg_hec_insert` = 0, byte 4 of a user cell is the upstream byte 4, forwarded unchanged.
- R5: The filler header is 00 00 00 01 (idle) when `cfg_fill_unassigned` = 0, and 00 00 00 00 (unassigned) when it is 1. Filler payload bytes are 0x6A. The filler check byte is always the computed CRC. It is XORed with 0x55 unless `cfg_fill_coset_off` = 1, independent of the user-cell coset setting.
- R6: With `cfg_scramble` = 1, each payload bit, taken MSB first, leaves as d XOR s[42], and that output bit shifts into s. The state s is 43 bits wide, zero after reset, and advances only on payload bits, continuously across user and filler cells. Header bytes and the check byte are never scrambled. With `cfg_scramble` = 0, payload bytes pass unchanged.
- R7: With `cfg_err_inject` = 1, bit 0 of the check byte is inverted in cell number k (counting cells sent since the enable) exactly when k mod (ON+OFF) < ON. ON is `cfg_err_on_cells` and OFF is `cfg_err_off_cells`.
- R8: A new rising edge of `cfg_err_inject` restarts the pattern: the next cell begins a fresh ON phase with k = 0. While the enable is low, no check byte is corrupted.
- R9: During reset, `out_data` and `out_sop` are 0. The first cell after reset starts on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Cell byte from the upstream queue |
| in_valid | input | 1 | `in_data` is valid |
| in_sop | input | 1 | `in_data` is byte 0 of a cell |
| in_ready | output | 1 | Byte is taken at the clock edge |
| cfg_hec_insert | input | 1 | 1: compute the check byte; 0: pass the upstream byte through |
| cfg_user_coset_off | input | 1 | Suppress the 0x55 coset on user cells |
| cfg_fill_coset_off | input | 1 | Suppress the 0x55 coset on filler cells |
| cfg_fill_unassigned | input | 1 | 1: unassigned filler header; 0: idle |
| cfg_scramble | input | 1 | Enable payload scrambling |
| cfg_err_inject | input | 1 | Enable periodic check-byte corruption |
| cfg_err_on_cells | input | 8 | Number of corrupted cells per period |
| cfg_err_off_cells | input | 8 | Number of clean cells per period |
| out_data | output | 8 | Output byte stream |
| out_sop | output | 1 | `out_data` is byte 0 of a cell |

## Verification
The error injector and the coset or pass-through selection both act on the same check byte in the same cycle. A wrong ordering or merge of the two would therefore show up as a wrong byte 4. The bench provokes this with a run that turns the coset off for user cells, keeps it on for fillers, and injects errors with a 2-on/3-off pattern over a mix of user and filler cells. The expected byte is built arithmetically as CRC, then XOR coset, then XOR bit 0 where (k mod 5) < 2. A second collision is forced by dropping and re-raising the injector enable in mid-cell, so the restart and the next cell boundary fall close together. The cell after the restart must be counted as k = 0.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;
   localparam logic [7:0] HEC_POLY  = 8'h07;
   localparam logic [7:0] HEC_COSET = 8'h55;

   // one byte of CRC-8, MSB first
   function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
      logic [7:0] c;
      logic       fb;
      c = crc;
      for (int i = 7; i >= 0; i--) begin
         fb = c[7] ^ d[i];
         c  = {c[6:0], 1'b0};
         if (fb) c = c ^ HEC_POLY;
      end
      return c;
   endfunction
endpackage

// File: rtl/atm_hec_gen.sv
module atm_hec_gen
   import atm_tx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cell_start,
   input  logic       hdr_byte,
   input  logic [7:0] byte_in,
   output logic [7:0] crc
);
   logic [7:0] crc_q;
   logic [7:0] seed;

   assign seed = cell_start ? 8'h00 : crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        crc_q <= 8'h00;
      else if (hdr_byte) crc_q <= crc8_step(seed, byte_in);
   end

   assign crc = crc_q;
endmodule

// File: rtl/atm_payload_scrambler.sv
module atm_payload_scrambler #(
   parameter int LEN    = 43,
   parameter bit ENABLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       advance,
   input  logic [7:0] din,
   output logic [7:0] dout
);
   generate
      if (ENABLE) begin : g_scr
         logic [LEN-1:0] st_q;
         logic [LEN-1:0] st_n;
         logic [7:0]     sb;

         always_comb begin
            st_n = st_q;
            sb   = 8'h00;
            for (int i = 7; i >= 0; i--) begin
               sb[i] = din[i] ^ st_n[LEN-1];
               st_n  = {st_n[LEN-2:0], sb[i]};
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n)       st_q <= '0;
            else if (advance) st_q <= st_n;
         end

         assign dout = sb;
      end else begin : g_bypass
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/atm_hec_err_pattern.sv
module atm_hec_err_pattern #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             cell_start,
   input  logic [CNT_W-1:0] on_len,
   input  logic [CNT_W-1:0] off_len,
   output logic             corrupt
);
   logic             en_q;
   logic             on_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rise;
   logic             eff_on;
   logic [CNT_W:0]   cnt_inc;

   assign rise    = enable && !en_q;
   assign eff_on  = rise ? 1'b1 : on_q;
   assign cnt_inc = rise ? (CNT_W+1)'(1) : ({1'b0, cnt_q} + 1'b1);
   assign corrupt = enable && cell_start && eff_on && (on_len != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         on_q  <= 1'b1;
         cnt_q <= '0;
      end else begin
         en_q <= enable;
         if (enable && cell_start) begin
            if (eff_on) begin
               if (cnt_inc >= {1'b0, on_len}) begin
                  cnt_q <= '0;
                  on_q  <= (off_len == '0);
               end else begin
                  cnt_q <= cnt_inc[CNT_W-1:0];
                  on_q  <= 1'b1;
               end
            end else begin
               if (cnt_inc >= {1'b0, off_len}) begin
                  cnt_q <= '0;
                  on_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_inc[CNT_W-1:0];
                  on_q  <= 1'b0;
               end
            end
         end else if (rise) begin
            cnt_q <= '0;
            on_q  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc
   import atm_tx_pkg::*;
#(
   parameter int         CELL_BYTES   = 53,
   parameter int         HDR_BYTES    = 4,
   parameter int         SCR_LEN      = 43,
   parameter bit         SCRAMBLER    = 1'b1,
   parameter int         ERR_CNT_W    = 8,
   parameter int         HEC_ERR_BIT  = 0,
   parameter logic [7:0] FILL_PAYLOAD = 8'h6A,
   parameter logic [7:0] IDLE_TAIL    = 8'h01
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [7:0]           in_data,
   input  logic                 in_valid,
   input  logic                 in_sop,
   output logic                 in_ready,
   input  logic                 cfg_hec_insert,
   input  logic                 cfg_user_coset_off,
   input  logic                 cfg_fill_coset_off,
   input  logic                 cfg_fill_unassigned,
   input  logic                 cfg_scramble,
   input  logic                 cfg_err_inject,
   input  logic [ERR_CNT_W-1:0] cfg_err_on_cells,
   input  logic [ERR_CNT_W-1:0] cfg_err_off_cells,
   output logic [7:0]           out_data,
   output logic                 out_sop
);
   localparam int         POS_W    = $clog2(CELL_BYTES);
   localparam logic [7:0] ERR_MASK = 8'(1) << HEC_ERR_BIT;

   generate
      if (HDR_BYTES + 1 >= CELL_BYTES) begin : g_bad_cell
         $error("cell must hold header, check byte and payload");
      end
      if (HEC_ERR_BIT < 0 || HEC_ERR_BIT > 7) begin : g_bad_bit
         $error("error bit must lie inside the check byte");
      end
      if (SCR_LEN < 2) begin : g_bad_scr
         $error("scrambler length too short");
      end
   endgenerate

   logic [POS_W-1:0] pos_q;
   logic             user_q;
   logic             err_q;
   logic             at_start;
   logic             start_user;
   logic             cell_user;
   logic             is_hdr;
   logic             is_hec;
   logic             is_pay;
   logic             last;
   logic [7:0]       fill_hdr;
   logic [7:0]       src_byte;
   logic [7:0]       crc;
   logic [7:0]       hec_calc;
   logic [7:0]       hec_base;
   logic [7:0]       hec_out;
   logic [7:0]       scr_byte;
   logic [7:0]       pay_out;
   logic [7:0]       next_byte;
   logic             corrupt;
   logic             coset_off;

   assign at_start   = (pos_q == '0);
   assign last       = (pos_q == POS_W'(CELL_BYTES - 1));
   assign start_user = at_start && in_valid && in_sop;
   assign cell_user  = at_start ? start_user : user_q;
   assign in_ready   = at_start || user_q;

   assign is_hdr = (pos_q <  POS_W'(HDR_BYTES));
   assign is_hec = (pos_q == POS_W'(HDR_BYTES));
   assign is_pay = !is_hdr && !is_hec;

   assign fill_hdr = (pos_q == POS_W'(HDR_BYTES - 1) && !cfg_fill_unassigned) ? IDLE_TAIL : 8'h00;
   assign src_byte = cell_user ? in_data : (is_hdr ? fill_hdr : FILL_PAYLOAD);

   atm_hec_gen u_hec (
      .clk        (clk),
      .rst_n      (rst_n),
      .cell_start (at_start),
      .hdr_byte   (is_hdr),
      .byte_in    (src_byte),
      .crc        (crc)
   );

   assign coset_off = cell_user ? cfg_user_coset_off : cfg_fill_coset_off;
   assign hec_calc  = crc ^ (coset_off ? 8'h00 : HEC_COSET);
   assign hec_base  = (cell_user && !cfg_hec_insert) ? in_data : hec_calc;
   assign hec_out   = hec_base ^ (err_q ? ERR_MASK : 8'h00);

   atm_hec_err_pattern #(.CNT_W(ERR_CNT_W)) u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (cfg_err_inject),
      .cell_start (at_start),
      .on_len     (cfg_err_on_cells),
      .off_len    (cfg_err_off_cells),
      .corrupt    (corrupt)
   );

   atm_payload_scrambler #(.LEN(SCR_LEN), .ENABLE(SCRAMBLER)) u_scr (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (is_pay && cfg_scramble),
      .din     (src_byte),
      .dout    (scr_byte)
   );

   assign pay_out   = cfg_scramble ? scr_byte : src_byte;
   assign next_byte = is_hdr ? src_byte : (is_hec ? hec_out : pay_out);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q    <= '0;
         user_q   <= 1'b0;
         err_q    <= 1'b0;
         out_data <= 8'h00;
         out_sop  <= 1'b0;
      end else begin
         pos_q    <= last ? '0 : pos_q + 1'b1;
         user_q   <= cell_user;
         if (at_start) err_q <= corrupt;
         out_data <= next_byte;
         out_sop  <= at_start;
      end
   end
endmodule

// File: rtl/atm_tx_cell_chk.sv
module atm_tx_cell_chk #(
   parameter int         CELL_BYTES   = 53,
   parameter int         HDR_BYTES    = 4,
   parameter int         POS_W        = 6,
   parameter logic [7:0] FILL_PAYLOAD = 8'h6A
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       in_data,
   input logic             in_valid,
   input logic             in_sop,
   input logic             cfg_scramble,
   input logic [7:0]       out_data,
   input logic             out_sop,
   input logic [POS_W-1:0] pos,
   input logic             cell_user
);
   logic [15:0] gap_q;
   logic        seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (out_sop) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else if (gap_q != 16'hFFFF) begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   a_r1_cell_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && out_sop) |-> (gap_q == 16'(CELL_BYTES - 1)));

   a_r2_user_start: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == '0 && in_valid && in_sop) |=> (out_sop && out_data == $past(in_data)));

   a_r5_filler_start: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == '0 && !(in_valid && in_sop)) |=> (out_sop && out_data == 8'h00));

   a_r6_plain_user_payload: assert property (@(posedge clk) disable iff (!rst_n)
      (pos > POS_W'(HDR_BYTES) && cell_user && !cfg_scramble) |=> (out_data == $past(in_data)));

   a_r5_filler_payload: assert property (@(posedge clk) disable iff (!rst_n)
      (pos > POS_W'(HDR_BYTES) && !cell_user && !cfg_scramble) |=> (out_data == FILL_PAYLOAD));
endmodule

bind atm_tx_cell_proc atm_tx_cell_chk #(
   .CELL_BYTES   (CELL_BYTES),
   .HDR_BYTES    (HDR_BYTES),
   .POS_W        (POS_W),
   .FILL_PAYLOAD (FILL_PAYLOAD)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_data      (in_data),
   .in_valid     (in_valid),
   .in_sop       (in_sop),
   .cfg_scramble (cfg_scramble),
   .out_data     (out_data),
   .out_sop      (out_sop),
   .pos          (pos_q),
   .cell_user    (user_q)
);

// File: tb/atm_tx_cell_proc_test.sv
module atm_tx_cell_proc_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_valid = 1'b0;
   logic       in_sop = 1'b0;
   logic       in_ready;
   logic       hec_ins = 1'b1, ucos = 1'b0, fcos = 1'b0, fill_un = 1'b0, scr = 1'b0, err_cfg = 1'b0;
   logic       toggle_low = 1'b0;
   logic       err_pin;
   logic [7:0] out_data;
   logic       out_sop;

   int tests = 0, fails = 0;
   int phase_base = 0;
   bit do_toggle = 0;

   always #10 clk = ~clk;
   assign err_pin = err_cfg & ~toggle_low;

   atm_tx_cell_proc uut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop),
      .in_ready(in_ready), .cfg_hec_insert(hec_ins), .cfg_user_coset_off(ucos),
      .cfg_fill_coset_off(fcos), .cfg_fill_unassigned(fill_un), .cfg_scramble(scr),
      .cfg_err_inject(err_pin), .cfg_err_on_cells(8'd2), .cfg_err_off_cells(8'd3),
      .out_data(out_data), .out_sop(out_sop)
   );

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] ucell(input int u, input int b);
      case (b)
         0: return 8'h80 | 8'(u & 127);
         1: return 8'(u * 3);
         2: return 8'h5A ^ 8'(u);
         3: return 8'(u * 5 + 1);
         4: return 8'hC3 ^ 8'(u);
         default: return 8'(u * 7 + b * 13);
      endcase
   endfunction

   // long division of header * x^8 by x^8+x^2+x+1
   function automatic logic [7:0] ref_hec(input logic [31:0] h);
      logic [39:0] r;
      r = {h, 8'h00};
      for (int i = 39; i >= 8; i--)
         if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
      return r[7:0];
   endfunction

   // receiver / reference model
   logic [7:0]  rbuf [53];
   int          idx = -1, gap = 0, k = 0, rx_u = 0, fills = 0, cells_rx = 0;
   bit          seen = 0, err_exp = 0;
   logic [42:0] dscr = '0;

   always @(negedge clk) begin
      if (!rst_n) begin
         idx = -1; seen = 0; gap = 0; k = 0; rx_u = phase_base; fills = 0; cells_rx = 0;
         dscr = '0; toggle_low = 1'b0;
      end else begin
         if (seen) gap++;
         if (out_sop) begin
            if (seen) check(gap == 53, "R1", "cell spacing", gap, 53);
            seen = 1; gap = 0; idx = 0;
            err_exp = err_cfg && ((k % 5) < 2);
            k++; cells_rx++;
         end else if (idx >= 0) begin
            idx++;
         end
         if (do_toggle && cells_rx == 6 && idx == 10) begin toggle_low = 1'b1; k = 0; end
         if (do_toggle && cells_rx == 6 && idx == 11) toggle_low = 1'b0;
         if (idx >= 0) rbuf[idx] = out_data;
         if (idx == 52) begin
            bit          user, ok;
            logic [7:0]  eh [4];
            logic [7:0]  hec_e, pay, pe, rb;
            string       tag;
            user = (rbuf[0] != 8'h00);
            if (user) begin
               for (int b = 0; b < 4; b++) eh[b] = ucell(rx_u, b);
               hec_e = hec_ins ? (ref_hec({eh[0], eh[1], eh[2], eh[3]}) ^ (ucos ? 8'h00 : 8'h55))
                               : ucell(rx_u, 4);
               tag = hec_ins ? "R3" : "R4";
            end else begin
               fills++;
               eh[0] = 0; eh[1] = 0; eh[2] = 0; eh[3] = fill_un ? 8'h00 : 8'h01;
               hec_e = ref_hec({eh[0], eh[1], eh[2], eh[3]}) ^ (fcos ? 8'h00 : 8'h55);
               tag = "R5";
            end
            for (int b = 0; b < 4; b++)
               check(rbuf[b] == eh[b], user ? "R2" : "R5", "header byte", rbuf[b], eh[b]);
            if (err_exp) hec_e = hec_e ^ 8'h01;
            if (err_cfg) tag = "R7/R8";
            check(rbuf[4] == hec_e, tag, "check byte", rbuf[4], hec_e);
            ok = 1;
            for (int b = 5; b < 53; b++) begin
               rb = rbuf[b];
               if (scr) begin
                  for (int i = 7; i >= 0; i--) begin
                     pay[i] = rb[i] ^ dscr[42];
                     dscr = {dscr[41:0], rb[i]};
                  end
               end else pay = rb;
               pe = user ? ucell(rx_u, b) : 8'h6A;
               if (pay != pe) begin
                  ok = 0;
                  $display("FAIL %s payload byte %0d: actual %0h expected %0h", scr ? "R6" : "R5", b, pay, pe);
               end
            end
            tests++;
            if (!ok) fails++;
            if (user) rx_u++;
            idx = -1;
         end
      end
   end

   task automatic send_cell(input int u, input bit junk);
      if (junk) begin
         @(negedge clk);
         in_valid = 1'b1; in_sop = 1'b0; in_data = 8'hEE;
         while (!in_ready) @(negedge clk);
      end
      for (int b = 0; b < 53; b++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sop = (b == 0); in_data = ucell(u, b);
         while (!in_ready) @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0;
   endtask

   task automatic run_phase(input int n, input bit hi, input bit uc, input bit fc, input bit fu,
                            input bit sc, input bit er, input bit tg, input bit junk);
      @(negedge clk);
      rst_n = 1'b0;
      hec_ins = hi; ucos = uc; fcos = fc; fill_un = fu; scr = sc; err_cfg = er; do_toggle = tg;
      repeat (3) @(negedge clk);
      check(out_sop == 1'b0, "R9", "sop in reset", out_sop, 0);
      check(out_data == 8'h00, "R9", "data in reset", out_data, 0);
      check(in_ready == 1'b1, "R2", "ready at boundary in reset", in_ready, 1);
      rst_n = 1'b1;
      for (int c = 0; c < n; c++) begin
         repeat ((c % 4) * 30) @(negedge clk);
         send_cell(phase_base + c, junk && (c == 2));
      end
      for (int w = 0; w < 2000 && rx_u != phase_base + n; w++) @(negedge clk);
      repeat (160) @(negedge clk);
      check(rx_u == phase_base + n, "R2", "user cells received", rx_u - phase_base, n);
      check(fills > 0, "R5", "filler cells seen", fills, 1);
      phase_base = phase_base + n;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // idle fillers, coset on, computed check byte, plain payload
      run_phase(8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      // pass-through check byte, unassigned fillers without coset, scrambling, dropped non-start byte
      run_phase(8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      // user coset off, filler coset on, scrambling, 2/3 error pattern with a mid-cell restart
      run_phase(10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule